// File: doc/BRIEF.md
# Asynchronous SRAM Access Sequencer

This block sits between a synchronous host and an external asynchronous static RAM of 512K words by 8 bits. The host raises a one-cycle request with a write flag, an address and write data. The sequencer then drives the memory's active-low chip enable, write enable and output enable, together with the address bus and a split data bus (data out, data in, drive enable). It keeps every timing limit by counting clock cycles. When the access ends it pulses `done` for one clock. For a read, the word captured from the memory is then held on `rdata`.

Each limit is given in nanoseconds and turned into a cycle count by rounding up against the clock period parameter. The limits are: address settling before chip enable, write pulse width, data setup, address/data hold, write recovery, read access, output-enable access, and bus turnaround after a read. The address is always settled before chip enable falls, which avoids the double sensing caused by skew. Output enable stays high for the whole of every write, so the data bus can be driven in the same cycle that write enable falls. Requests that arrive while an access is in progress are dropped. The `idle` output tells the host when the next request will be accepted.

Top module: `asram_ctrl`

## Requirements
- R1: While reset is asserted and right after it, `idle`=1, `done`=0, `mem_dq_oe`=0, and `mem_ce_n`, `mem_we_n` and `mem_oe_n` are all 1.
- R2: The address on `mem_addr` is stable for at least one clock before `mem_ce_n` falls, and it stays unchanged for as long as `mem_ce_n` is low.
- R3: A write drives `mem_ce_n`=0, `mem_we_n`=0 and `mem_oe_n`=1 with `mem_dq_oe`=1 and constant `mem_dq_out`. This low window lasts at least max(write pulse, data setup) = 20 ns.
- R4: After `mem_we_n` rises, `mem_addr`, `mem_dq_out` and `mem_dq_oe`=1 stay unchanged for at least the hold time (2 ns, one clock minimum).
- R5: Between the end of one write and the start of the next, `mem_we_n` stays high for at least 5 ns.
- R6: A read drives `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 with `mem_dq_oe`=0. The data is captured only after at least 20 ns of chip enable and 10 ns of output enable, and `rdata` then equals the last value written to that address.
- R7: `mem_dq_oe` is never 1 while `mem_oe_n` is 0. After `mem_oe_n` rises, at least 10 ns pass before `mem_dq_oe` rises.
- R8: `done` is high for exactly one clock. With default parameters it comes 5 clocks after a write request is sampled and 4 clocks after a read request is sampled.
- R9: `idle` is 1 only when the next request will be accepted. A request raised while `idle`=0 has no effect on memory contents or on the operation in progress.
- R10: `rdata` keeps its value until the next read completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | 1 | Request strobe, sampled when idle |
| wr | input | 1 | 1 = write, 0 = read |
| addr | input | 19 | Word address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Last word read |
| done | output | 1 | One-clock completion pulse |
| idle | output | 1 | Ready for a new request |
| mem_addr | output | 19 | Memory address bus |
| mem_ce_n | output | 1 | Memory chip enable, active low |
| mem_we_n | output | 1 | Memory write enable, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_dq_out | output | 8 | Data driven toward memory |
| mem_dq_in | input | 8 | Data returned by memory |
| mem_dq_oe | output | 1 | Drive enable for the data bus |

## Verification
A host request can arrive in the same cycle as a step of an access already in progress: a timer reload, the read capture, or the turnaround after a read. The request must be dropped while the step goes ahead unchanged. The bench raises a stray write request at a random offset inside each busy window. It then checks that the done latency is unchanged, and later reads the stray address back to confirm it was never written. The memory model in the bench returns corrupted data until the access time has elapsed, so a capture that comes too early shows up as a data mismatch.

// File: rtl/asram_pkg.sv
package asram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_WPULS = 3'd2,
    ST_WHOLD = 3'd3,
    ST_READ  = 3'd4,
    ST_RECOV = 3'd5
  } seq_state_e;

  // round a nanosecond limit up to clock cycles, never below lo
  function automatic int ns_to_cyc(input int ns, input int per, input int lo);
    int c;
    c = (ns + per - 1) / per;
    return (c < lo) ? lo : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/asram_timer.sv
module asram_timer #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          zero
);

  logic [CW-1:0] cnt_q, cnt_d;

  assign zero = (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    if (load)       cnt_d = load_val;
    else if (!zero) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/asram_seq.sv
module asram_seq
  import asram_pkg::*;
#(
  parameter int CW   = 2,
  parameter int ASET = 1,
  parameter int WP   = 2,
  parameter int HOLD = 1,
  parameter int RECW = 1,
  parameter int RD   = 2,
  parameter int TURN = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req,
  input  logic          wr,
  input  logic          zero,
  output logic          load,
  output logic [CW-1:0] load_val,
  output logic          accept,
  output logic          capture,
  output logic          ce_n,
  output logic          we_n,
  output logic          oe_n,
  output logic          dq_oe,
  output logic          done,
  output logic          idle
);

  seq_state_e st_q, st_d;
  logic wr_q, wr_d;
  logic done_d;
  logic ce_n_d, we_n_d, oe_n_d, dq_oe_d;

  // next-state and timer reload
  always_comb begin
    st_d     = st_q;
    wr_d     = wr_q;
    load     = 1'b0;
    load_val = '0;
    accept   = 1'b0;
    capture  = 1'b0;
    done_d   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req) begin
        st_d     = ST_SETUP;
        wr_d     = wr;
        accept   = 1'b1;
        load     = 1'b1;
        load_val = CW'(ASET - 1);
      end
      ST_SETUP: if (zero) begin
        load = 1'b1;
        if (wr_q) begin
          st_d     = ST_WPULS;
          load_val = CW'(WP - 1);
        end else begin
          st_d     = ST_READ;
          load_val = CW'(RD - 1);
        end
      end
      ST_WPULS: if (zero) begin
        st_d     = ST_WHOLD;
        load     = 1'b1;
        load_val = CW'(HOLD - 1);
      end
      ST_WHOLD: if (zero) begin
        st_d     = ST_RECOV;
        load     = 1'b1;
        load_val = CW'(RECW - 1);
      end
      ST_READ: if (zero) begin
        st_d     = ST_RECOV;
        capture  = 1'b1;
        load     = 1'b1;
        load_val = CW'(TURN - 1);
      end
      ST_RECOV: if (zero) begin
        st_d   = ST_IDLE;
        done_d = 1'b1;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // memory pins follow the next state so they leave flops directly
  always_comb begin
    ce_n_d  = !((st_d == ST_WPULS) || (st_d == ST_READ));
    we_n_d  = (st_d != ST_WPULS);
    oe_n_d  = (st_d != ST_READ);
    dq_oe_d = (st_d == ST_WPULS) || (st_d == ST_WHOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      wr_q  <= 1'b0;
      done  <= 1'b0;
      ce_n  <= 1'b1;
      we_n  <= 1'b1;
      oe_n  <= 1'b1;
      dq_oe <= 1'b0;
    end else begin
      st_q  <= st_d;
      wr_q  <= wr_d;
      done  <= done_d;
      ce_n  <= ce_n_d;
      we_n  <= we_n_d;
      oe_n  <= oe_n_d;
      dq_oe <= dq_oe_d;
    end
  end

  assign idle = (st_q == ST_IDLE);

endmodule

// File: rtl/asram_dpath.sv
module asram_dpath #(
  parameter int AW = 19,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept,
  input  logic          capture,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] dq_in,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] dq_out,
  output logic [DW-1:0] rdata
);

  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdat_q, rdat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      wdat_q <= '0;
    end else if (accept) begin
      addr_q <= addr;
      wdat_q <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdat_q <= '0;
    else if (capture) rdat_q <= dq_in;
  end

  assign mem_addr = addr_q;
  assign dq_out   = wdat_q;
  assign rdata    = rdat_q;

endmodule

// File: rtl/asram_ctrl.sv
module asram_ctrl
  import asram_pkg::*;
#(
  parameter int ADDR_W    = 19,
  parameter int DATA_W    = 8,
  parameter int CLK_NS    = 10,
  parameter int T_ASU_NS  = 5,
  parameter int T_WP_NS   = 20,
  parameter int T_DS_NS   = 15,
  parameter int T_DH_NS   = 2,
  parameter int T_WR_NS   = 5,
  parameter int T_AA_NS   = 20,
  parameter int T_OE_NS   = 10,
  parameter int T_TURN_NS = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req,
  input  logic              wr,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              done,
  output logic              idle,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_ce_n,
  output logic              mem_we_n,
  output logic              mem_oe_n,
  output logic [DATA_W-1:0] mem_dq_out,
  input  logic [DATA_W-1:0] mem_dq_in,
  output logic              mem_dq_oe
);

  localparam int ASET = ns_to_cyc(T_ASU_NS, CLK_NS, 1);
  localparam int WP   = imax(ns_to_cyc(T_WP_NS, CLK_NS, 1), ns_to_cyc(T_DS_NS, CLK_NS, 1));
  localparam int HOLD = ns_to_cyc(T_DH_NS, CLK_NS, 1);
  localparam int RECW = ns_to_cyc(T_WR_NS, CLK_NS, 1);
  localparam int RD   = imax(ns_to_cyc(T_AA_NS, CLK_NS, 1), ns_to_cyc(T_OE_NS, CLK_NS, 1));
  localparam int TURN = ns_to_cyc(T_TURN_NS, CLK_NS, 1);
  localparam int MAXC = imax(imax(imax(ASET, WP), imax(HOLD, RECW)), imax(RD, TURN));
  localparam int CW   = $clog2(MAXC + 1);

  logic          load, zero, accept, capture;
  logic [CW-1:0] load_val;

  asram_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (load),
    .load_val (load_val),
    .zero     (zero)
  );

  asram_seq #(
    .CW(CW), .ASET(ASET), .WP(WP), .HOLD(HOLD),
    .RECW(RECW), .RD(RD), .TURN(TURN)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .wr       (wr),
    .zero     (zero),
    .load     (load),
    .load_val (load_val),
    .accept   (accept),
    .capture  (capture),
    .ce_n     (mem_ce_n),
    .we_n     (mem_we_n),
    .oe_n     (mem_oe_n),
    .dq_oe    (mem_dq_oe),
    .done     (done),
    .idle     (idle)
  );

  asram_dpath #(.AW(ADDR_W), .DW(DATA_W)) u_dpath (
    .clk      (clk),
    .rst_n    (rst_n),
    .accept   (accept),
    .capture  (capture),
    .addr     (addr),
    .wdata    (wdata),
    .dq_in    (mem_dq_in),
    .mem_addr (mem_addr),
    .dq_out   (mem_dq_out),
    .rdata    (rdata)
  );

endmodule

// File: rtl/asram_ctrl_chk.sv
module asram_ctrl_chk #(
  parameter int ADDR_W = 19,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              idle,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ce_n,
  input logic              mem_we_n,
  input logic              mem_oe_n,
  input logic [DATA_W-1:0] mem_dq_out,
  input logic              mem_dq_oe
);

  p_idle_pins_r1: assert property (@(posedge clk) disable iff (!rst_n)
    idle |-> (mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe));

  p_addr_ce_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  p_addr_settled_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mem_ce_n) |-> $stable(mem_addr));

  p_write_pins_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> (!mem_ce_n && mem_oe_n && mem_dq_oe));

  p_write_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_we_n) |-> (mem_dq_oe && $stable(mem_dq_out) && $stable(mem_addr)));

  p_read_pins_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> (mem_we_n && !mem_ce_n && !mem_dq_oe));

  p_no_contention_r7: assert property (@(posedge clk) disable iff (!rst_n)
    mem_dq_oe |-> mem_oe_n);

  p_turnaround_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_oe_n) |=> !mem_dq_oe);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> idle);

endmodule

bind asram_ctrl asram_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .done       (done),
  .idle       (idle),
  .mem_addr   (mem_addr),
  .mem_ce_n   (mem_ce_n),
  .mem_we_n   (mem_we_n),
  .mem_oe_n   (mem_oe_n),
  .mem_dq_out (mem_dq_out),
  .mem_dq_oe  (mem_dq_oe)
);

// File: tb/asram_ctrl_test.sv
module asram_ctrl_test;

  localparam int PER = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req, wr;
  logic [18:0] addr;
  logic [7:0]  wdata, rdata;
  logic        done, idle;
  logic [18:0] mem_addr;
  logic        mem_ce_n, mem_we_n, mem_oe_n, mem_dq_oe;
  logic [7:0]  mem_dq_out, mem_dq_in;

  int checks = 0;
  int errors = 0;
  bit ended  = 0;

  logic [7:0] sram  [int];   // contents as written through the pins
  logic [7:0] shadow[int];   // contents as the host intended

  always #(PER/2) clk = ~clk;

  asram_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req(req), .wr(wr), .addr(addr), .wdata(wdata),
    .rdata(rdata), .done(done), .idle(idle), .mem_addr(mem_addr),
    .mem_ce_n(mem_ce_n), .mem_we_n(mem_we_n), .mem_oe_n(mem_oe_n),
    .mem_dq_out(mem_dq_out), .mem_dq_in(mem_dq_in), .mem_dq_oe(mem_dq_oe)
  );

  function automatic int cdiv(input int ns);
    int c;
    c = (ns + PER - 1) / PER;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int lat(input bit w);
    int rdc;
    rdc = (cdiv(20) > cdiv(10)) ? cdiv(20) : cdiv(10);
    if (w) return cdiv(5) + ((cdiv(20) > cdiv(15)) ? cdiv(20) : cdiv(15)) + cdiv(2) + cdiv(5);
    return cdiv(5) + rdc + cdiv(10);
  endfunction

  function automatic logic [7:0] fill(input logic [18:0] a);
    return a[7:0] ^ 8'hA5;
  endfunction

  function automatic logic [7:0] sram_rd(input logic [18:0] a);
    return sram.exists(int'(a)) ? sram[int'(a)] : fill(a);
  endfunction

  function automatic logic [7:0] exp_rd(input logic [18:0] a);
    return shadow.exists(int'(a)) ? shadow[int'(a)] : fill(a);
  endfunction

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", rq, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  // memory model and pin-protocol monitor
  logic [18:0] p_addr;
  logic [7:0]  w_data;
  bit   in_w = 0, seen_w = 0;
  int   wl_cnt = 0, whi_cnt = 0, rd_cnt = 0, oe_hi = 0;
  logic p_dq_oe = 1'b0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (!mem_ce_n) chk(mem_addr == p_addr, "R2 addr settled", int'(mem_addr), int'(p_addr));
      if (mem_dq_oe) chk(mem_oe_n, "R7 contention", int'(mem_oe_n), 1);
      if (mem_dq_oe && !p_dq_oe) chk(oe_hi * PER >= 10, "R7 turnaround", oe_hi * PER, 10);
      if (!mem_ce_n && !mem_we_n) begin
        if (!in_w) begin
          if (seen_w) chk(whi_cnt * PER >= 5, "R5 recovery", whi_cnt * PER, 5);
          in_w = 1; wl_cnt = 0; w_data = mem_dq_out;
        end
        wl_cnt++;
        chk(mem_oe_n && mem_dq_oe && mem_dq_out == w_data, "R3 write pins",
            int'({mem_oe_n, mem_dq_oe, mem_dq_out}), int'({2'b11, w_data}));
      end else if (in_w) begin
        chk(wl_cnt * PER >= 20 && wl_cnt * PER >= 15, "R3 pulse width", wl_cnt * PER, 20);
        chk(mem_dq_oe && mem_dq_out == w_data && mem_addr == p_addr, "R4 hold",
            int'(mem_dq_out), int'(w_data));
        sram[int'(p_addr)] = w_data;
        in_w = 0; seen_w = 1; whi_cnt = 0;
      end
      if (mem_we_n) whi_cnt++;
      if (mem_oe_n) oe_hi++; else oe_hi = 0;
      if (!mem_ce_n && !mem_oe_n && mem_we_n) rd_cnt++; else rd_cnt = 0;
      mem_dq_in = (rd_cnt * PER >= 20) ? sram_rd(mem_addr) : ~sram_rd(mem_addr);
      p_addr  = mem_addr;
      p_dq_oe = mem_dq_oe;
    end
  end

  // one host operation, optionally with a stray request poked at offset pk
  task automatic host_op(input bit w, input logic [18:0] a, input logic [7:0] d, input int pk);
    int n;
    logic [7:0] exp, held;
    while (!idle) @(negedge clk);
    req = 1'b1; wr = w; addr = a; wdata = d;
    @(negedge clk);
    n = 1;
    chk(!idle, "R9 busy after accept", int'(idle), 0);
    while (!done && n < 64) begin
      if (pk != 0 && n == pk) begin
        req = 1'b1; wr = 1'b1; addr = 19'h7FFF3; wdata = 8'h3C;
      end else req = 1'b0;
      @(negedge clk);
      n++;
    end
    req = 1'b0;
    chk(n == lat(w) + 1, "R8 latency", n - 1, lat(w));
    chk(idle, "R9 idle with done", int'(idle), 1);
    if (w) shadow[int'(a)] = d;
    else begin
      exp = exp_rd(a);
      chk(rdata == exp, "R6 read data", int'(rdata), int'(exp));
    end
    held = rdata;
    @(negedge clk);
    chk(!done, "R8 single pulse", int'(done), 0);
    chk(rdata == held, "R10 rdata held", int'(rdata), int'(held));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    chk(1'b0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [18:0] a;
    void'($urandom(32'd1357));
    rst_n = 1'b0; req = 1'b0; wr = 1'b0; addr = '0; wdata = '0; mem_dq_in = '0;
    repeat (3) @(negedge clk);
    chk(idle && !done && !mem_dq_oe && mem_ce_n && mem_we_n && mem_oe_n,
        "R1 reset pins", int'({idle, done, mem_dq_oe, mem_ce_n, mem_we_n, mem_oe_n}), 6'b100111);
    rst_n = 1'b1;
    @(negedge clk);
    chk(idle && mem_ce_n && mem_we_n && mem_oe_n && !mem_dq_oe, "R1 after release",
        int'(idle), 1);
    // directed: boundaries, unwritten read, back-to-back writes
    host_op(1'b0, 19'h00010, 8'h00, 0);         // R6 unwritten location
    host_op(1'b1, 19'h00000, 8'h5A, 0);
    host_op(1'b1, 19'h7FFFF, 8'hC3, 0);         // R5 back-to-back writes
    host_op(1'b0, 19'h00000, 8'h00, 0);
    host_op(1'b0, 19'h7FFFF, 8'h00, 0);
    host_op(1'b1, 19'h00000, 8'hFF, 2);         // R9 stray request mid write
    host_op(1'b0, 19'h00000, 8'h00, 3);         // R9 stray request during turnaround
    host_op(1'b0, 19'h7FFF3, 8'h00, 0);         // R9 stray address never written
    // random mix with stray requests at random offsets
    for (int i = 0; i < 300; i++) begin
      a = ($urandom % 4 == 0) ? 19'($urandom) : 19'($urandom % 16);
      if (a == 19'h7FFF3) a = 19'h1;
      host_op(1'($urandom), a, 8'($urandom), int'($urandom % 5));
    end
    host_op(1'b0, 19'h7FFF3, 8'h00, 0);         // R9 final confirmation
    finish_run();
  end

endmodule